// File: doc/BRIEF.md
# Configurable UART Frame Engine

This block is the serial core of an asynchronous serial port. It converts parallel characters to a serial bit stream and back, using a frame format chosen at run time. A separate register block supplies the configuration inputs and owns any FIFOs or interrupts. The transmit side takes one character at a time through a ready/valid handshake. It shifts the character out least significant bit first. The character sits between a low start bit and one or two high stop bits, with an optional parity bit after the data. The line idles high.

The receive side synchronises the incoming line and detects the falling edge of a start bit. It takes one sample per bit, at a programmed offset from the start of that bit, instead of using a fixed oversampling ratio. Each character comes back with three flags: parity error, stop (framing) error and break. A mode input lets every stop error also be reported as a break. The bit period in clock cycles equals the programmed divisor. Software sets the divisor to the clock rate divided by the baud rate and normally sets the sample offset to half the divisor.

Top module: `uart_frame_engine`

## Requirements
- R1: After reset `txd` is 1, `rx_valid` is 0, and with all enables low `tx_ready` is 0.
- R2: A transmitted frame is a start bit of 0, then the data bits least significant first, then the optional parity bit, then stop bits of 1. Each bit lasts exactly `cfg_divisor` clock cycles. The start bit begins in the cycle after the accepting clock edge.
- R3: `cfg_width` selects the character length: code 0 is 5 bits, 1 is 6, 2 is 7 and 3 is 8. Only that many data bits are sent and received.
- R4: With `cfg_par_en` = 1, a parity bit follows the data. It makes the count of ones in data plus parity even when `cfg_par_even` = 1 and odd when it is 0.
- R5: With `cfg_two_stop` = 1, two stop bits are sent, and the receiver checks both of them.
- R6: The transmitter works only while both `cfg_enable` and `cfg_tx_en` are 1. Otherwise `tx_ready` is 0, and from the next cycle on `txd` is 1.
- R7: The receiver works only while both `cfg_enable` and `cfg_rx_en` are 1. Otherwise no character is returned.
- R8: The receiver samples each bit `cfg_sample` cycles after it detects that bit's start. The line must still be low at the start-bit sample, or the receiver drops the start and returns to idle without returning a character.
- R9: `rx_par_err` is 1 when the received parity bit does not match the parity selected by `cfg_par_even`.
- R10: `rx_stop_err` is 1 when any stop-bit sample is 0. After a stop error the receiver waits for the line to go high before it looks for a new start bit.
- R11: `rx_break` is 1 when every sample of the frame, including the stop samples, is 0. Such a character also has `rx_stop_err` = 1 and data 0.
- R12: With `cfg_stop_is_break` = 1, every character that has a stop error also has `rx_break` = 1.
- R13: A returned character stays on `rx_data` with `rx_valid` = 1 until a cycle in which `rx_ready` is 1. Data bits above the selected width read as 0.
- R14: `tx_ready` is 0 from the accepting edge until the last stop bit has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_enable | input | 1 | Global enable for both directions |
| cfg_tx_en | input | 1 | Transmitter enable |
| cfg_rx_en | input | 1 | Receiver enable |
| cfg_width | input | 2 | Character length code (0..3 gives 5..8 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | 1 selects even parity, 0 selects odd |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_stop_is_break | input | 1 | Also report every stop error as a break |
| cfg_divisor | input | DIV_W | Bit period in clock cycles (at least 2) |
| cfg_sample | input | DIV_W | Sample offset within a bit (below the divisor) |
| tx_data | input | 8 | Character to send |
| tx_valid | input | 1 | `tx_data` is valid |
| tx_ready | output | 1 | Transmitter can accept a character |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input (asynchronous) |
| rx_data | output | 8 | Received character |
| rx_par_err | output | 1 | Parity error flag for `rx_data` |
| rx_stop_err | output | 1 | Stop-bit error flag for `rx_data` |
| rx_break | output | 1 | Break flag for `rx_data` |
| rx_valid | output | 1 | Received character is valid |
| rx_ready | input | 1 | Consumer takes the character |

## Verification
Some relations are checked on every cycle. The line is idle while the transmitter is disabled, a start bit follows every accepted handshake, `tx_ready` stays low while a frame is on the line, and a received character is held until it is taken. A break always carries a stop error, and a disabled receiver never raises `rx_valid`. The exact bit pattern, the bit timing, the parity and width encodings, the sample-point placement, start-bit rejection and recovery after an error can only be shown by the bench. The bench checks each of these by comparing the line, or the returned characters, with frames it computes itself, in loopback and with waveforms it drives itself.

// File: rtl/uart_fe_pkg.sv
`timescale 1ns/1ps
package uart_fe_pkg;

    localparam int DATA_W  = 8;
    localparam int FRAME_W = 12;

    typedef enum logic [1:0] {
        WIDTH_5 = 2'd0,
        WIDTH_6 = 2'd1,
        WIDTH_7 = 2'd2,
        WIDTH_8 = 2'd3
    } width_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP,
        RX_WAIT_HIGH
    } rx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              par_err;
        logic              stop_err;
        logic              brk;
    } rx_char_t;

    function automatic logic [3:0] data_bits(width_e w);
        return 4'd5 + {2'b00, w};
    endfunction

    function automatic logic [DATA_W-1:0] data_mask(width_e w);
        return 8'hFF >> (4'd8 - data_bits(w));
    endfunction

    function automatic logic par_bit(logic [DATA_W-1:0] d, logic even);
        return even ? ^d : ~^d;
    endfunction

    // Whole frame, bit 0 first on the line; unused upper positions are 1.
    function automatic logic [FRAME_W-1:0] make_frame(logic [DATA_W-1:0] d, width_e w,
                                                     logic par_en, logic even);
        logic [FRAME_W-1:0] f;
        logic [FRAME_W-1:0] dx;
        logic [DATA_W-1:0]  dm;
        int n;
        n  = int'(data_bits(w));
        dm = d & data_mask(w);
        dx = {{(FRAME_W-DATA_W){1'b0}}, dm};
        f  = '1;
        f[0] = 1'b0;
        for (int i = 1; i < FRAME_W; i++) begin
            if (i <= n)
                f[i] = dx[i-1];
            else if (par_en && i == n + 1)
                f[i] = par_bit(dm, even);
        end
        return f;
    endfunction

    function automatic logic [3:0] frame_len(width_e w, logic par_en, logic two_stop);
        return 4'd2 + data_bits(w) + {3'b000, par_en} + {3'b000, two_stop};
    endfunction

endpackage

// File: rtl/uart_fe_sync.sv
`timescale 1ns/1ps
module uart_fe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    q[s] <= 1'b1;
                else if (s == 0)
                    q[s] <= d_in;
                else
                    q[s] <= q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign d_out = q[STAGES-1];
endmodule

// File: rtl/uart_fe_tx.sv
`timescale 1ns/1ps
module uart_fe_tx
    import uart_fe_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic [DIV_W-1:0]  divisor,
    input  width_e            width,
    input  logic              par_en,
    input  logic              par_even,
    input  logic              two_stop,
    input  logic [DATA_W-1:0] data,
    input  logic              valid,
    output logic              ready,
    output logic              line
);
    logic               busy;
    logic [FRAME_W-1:0] shreg;
    logic [3:0]         left;
    logic [DIV_W-1:0]   cnt;
    logic               bit_end;

    assign bit_end = (cnt == divisor - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            busy  <= 1'b0;
            shreg <= '1;
            left  <= '0;
            cnt   <= '0;
        end else if (!busy) begin
            if (valid) begin
                shreg <= make_frame(data, width, par_en, par_even);
                left  <= frame_len(width, par_en, two_stop);
                cnt   <= '0;
                busy  <= 1'b1;
            end
        end else if (bit_end) begin
            cnt   <= '0;
            shreg <= {1'b1, shreg[FRAME_W-1:1]};
            left  <= left - 4'd1;
            if (left == 4'd1)
                busy <= 1'b0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign ready = active && !busy;
    assign line  = busy ? shreg[0] : 1'b1;
endmodule

// File: rtl/uart_fe_rx.sv
`timescale 1ns/1ps
module uart_fe_rx
    import uart_fe_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             line,
    input  logic [DIV_W-1:0] divisor,
    input  logic [DIV_W-1:0] sample,
    input  width_e           width,
    input  logic             par_en,
    input  logic             par_even,
    input  logic             two_stop,
    input  logic             stop_is_break,
    output rx_char_t         char_q,
    output logic             valid,
    input  logic             ready
);
    rx_state_e         st;
    logic [DIV_W-1:0]  cnt;
    logic [2:0]        idx;
    logic [DATA_W-1:0] dat;
    logic              zero_so_far;
    logic              perr;
    logic              serr;
    logic              second_stop;

    logic              smp;
    logic              bit_end;
    logic [DIV_W-1:0]  cnt_nxt;
    logic              last_data;
    logic              last_stop;
    logic              fin_serr;
    logic              fin_brk;

    always_comb begin
        smp       = (cnt == sample);
        bit_end   = (cnt == divisor - 1'b1);
        cnt_nxt   = bit_end ? '0 : cnt + 1'b1;
        last_data = ({1'b0, idx} == data_bits(width) - 4'd1);
        last_stop = (second_stop == two_stop);
        fin_serr  = serr || !line;
        fin_brk   = (zero_so_far && !line) || (stop_is_break && fin_serr);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= RX_IDLE;
            cnt         <= '0;
            idx         <= '0;
            dat         <= '0;
            zero_so_far <= 1'b0;
            perr        <= 1'b0;
            serr        <= 1'b0;
            second_stop <= 1'b0;
            char_q      <= '0;
            valid       <= 1'b0;
        end else begin
            if (valid && ready)
                valid <= 1'b0;
            if (!active) begin
                st  <= RX_IDLE;
                cnt <= '0;
            end else begin
                unique case (st)
                    RX_IDLE: begin
                        if (!line) begin
                            st          <= RX_START;
                            cnt         <= '0;
                            idx         <= '0;
                            dat         <= '0;
                            zero_so_far <= 1'b1;
                            perr        <= 1'b0;
                            serr        <= 1'b0;
                            second_stop <= 1'b0;
                        end
                    end
                    RX_START: begin
                        cnt <= cnt_nxt;
                        if (smp && line)
                            st <= RX_IDLE;
                        else if (bit_end)
                            st <= RX_DATA;
                    end
                    RX_DATA: begin
                        cnt <= cnt_nxt;
                        if (smp) begin
                            dat[idx] <= line;
                            if (line)
                                zero_so_far <= 1'b0;
                        end
                        if (bit_end) begin
                            idx <= idx + 3'd1;
                            if (last_data)
                                st <= par_en ? RX_PARITY : RX_STOP;
                        end
                    end
                    RX_PARITY: begin
                        cnt <= cnt_nxt;
                        if (smp) begin
                            perr <= (line != par_bit(dat, par_even));
                            if (line)
                                zero_so_far <= 1'b0;
                        end
                        if (bit_end)
                            st <= RX_STOP;
                    end
                    RX_STOP: begin
                        cnt <= cnt_nxt;
                        if (smp) begin
                            if (last_stop) begin
                                char_q.data     <= dat;
                                char_q.par_err  <= perr;
                                char_q.stop_err <= fin_serr;
                                char_q.brk      <= fin_brk;
                                valid           <= 1'b1;
                                cnt             <= '0;
                                st              <= fin_serr ? RX_WAIT_HIGH : RX_IDLE;
                            end else begin
                                serr        <= !line;
                                second_stop <= 1'b1;
                                if (line)
                                    zero_so_far <= 1'b0;
                            end
                        end
                    end
                    RX_WAIT_HIGH: begin
                        if (line)
                            st <= RX_IDLE;
                    end
                    default: st <= RX_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/uart_frame_engine.sv
`timescale 1ns/1ps
module uart_frame_engine
    import uart_fe_pkg::*;
#(
    parameter int DIV_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_enable,
    input  logic             cfg_tx_en,
    input  logic             cfg_rx_en,
    input  logic [1:0]       cfg_width,
    input  logic             cfg_par_en,
    input  logic             cfg_par_even,
    input  logic             cfg_two_stop,
    input  logic             cfg_stop_is_break,
    input  logic [DIV_W-1:0] cfg_divisor,
    input  logic [DIV_W-1:0] cfg_sample,
    input  logic [7:0]       tx_data,
    input  logic             tx_valid,
    output logic             tx_ready,
    output logic             txd,
    input  logic             rxd,
    output logic [7:0]       rx_data,
    output logic             rx_par_err,
    output logic             rx_stop_err,
    output logic             rx_break,
    output logic             rx_valid,
    input  logic             rx_ready
);
    width_e   width;
    logic     tx_active;
    logic     rx_active;
    logic     rx_line;
    rx_char_t rx_char;

    assign width     = width_e'(cfg_width);
    assign tx_active = cfg_enable && cfg_tx_en;
    assign rx_active = cfg_enable && cfg_rx_en;

    uart_fe_tx #(.DIV_W(DIV_W)) tx_i (
        .clk      (clk),
        .rst      (rst),
        .active   (tx_active),
        .divisor  (cfg_divisor),
        .width    (width),
        .par_en   (cfg_par_en),
        .par_even (cfg_par_even),
        .two_stop (cfg_two_stop),
        .data     (tx_data),
        .valid    (tx_valid),
        .ready    (tx_ready),
        .line     (txd)
    );

    uart_fe_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst   (rst),
        .d_in  (rxd),
        .d_out (rx_line)
    );

    uart_fe_rx #(.DIV_W(DIV_W)) rx_i (
        .clk           (clk),
        .rst           (rst),
        .active        (rx_active),
        .line          (rx_line),
        .divisor       (cfg_divisor),
        .sample        (cfg_sample),
        .width         (width),
        .par_en        (cfg_par_en),
        .par_even      (cfg_par_even),
        .two_stop      (cfg_two_stop),
        .stop_is_break (cfg_stop_is_break),
        .char_q        (rx_char),
        .valid         (rx_valid),
        .ready         (rx_ready)
    );

    assign rx_data     = rx_char.data;
    assign rx_par_err  = rx_char.par_err;
    assign rx_stop_err = rx_char.stop_err;
    assign rx_break    = rx_char.brk;
endmodule

// File: rtl/uart_frame_engine_chk.sv
`timescale 1ns/1ps
module uart_frame_engine_chk (
    input logic clk,
    input logic rst,
    input logic cfg_enable,
    input logic cfg_tx_en,
    input logic cfg_rx_en,
    input logic tx_valid,
    input logic tx_ready,
    input logic txd,
    input logic rx_valid,
    input logic rx_ready,
    input logic rx_stop_err,
    input logic rx_break
);
    p_line_idle_when_off_r6: assert property (@(posedge clk) disable iff (rst)
        !(cfg_enable && cfg_tx_en) |=> txd);

    p_no_accept_when_off_r6: assert property (@(posedge clk) disable iff (rst)
        !(cfg_enable && cfg_tx_en) |-> !tx_ready);

    p_start_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready) |=> !txd);

    p_busy_while_low_r14: assert property (@(posedge clk) disable iff (rst)
        !txd |-> !tx_ready);

    p_hold_until_taken_r13: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && !rx_ready) |=> rx_valid);

    p_break_has_stop_err_r11: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_break) |-> rx_stop_err);

    p_quiet_when_off_r7: assert property (@(posedge clk) disable iff (rst)
        (!(cfg_enable && cfg_rx_en) && !rx_valid) |=> !rx_valid);
endmodule

bind uart_frame_engine uart_frame_engine_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .cfg_enable  (cfg_enable),
    .cfg_tx_en   (cfg_tx_en),
    .cfg_rx_en   (cfg_rx_en),
    .tx_valid    (tx_valid),
    .tx_ready    (tx_ready),
    .txd         (txd),
    .rx_valid    (rx_valid),
    .rx_ready    (rx_ready),
    .rx_stop_err (rx_stop_err),
    .rx_break    (rx_break)
);

// File: tb/uart_frame_engine_tb_top.sv
`timescale 1ns/1ps
module uart_frame_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        g_en = 0, t_en = 0, r_en = 0;
    logic [1:0]  wsel = 2'd3;
    logic        pe = 0, ev = 0, ts = 0, sb = 0;
    logic [15:0] div = 16'd8, smp = 16'd4;
    logic [7:0]  tx_data = 8'h00;
    logic        tx_valid = 0;
    logic        tx_ready, txd;
    logic        loop_mode = 1'b1;
    logic        rxd_drv = 1'b1;
    logic        rxd_line;
    logic [7:0]  rx_data;
    logic        rx_par_err, rx_stop_err, rx_break, rx_valid;
    logic        rx_ready = 1'b1;

    int n_chk = 0;
    int n_err = 0;
    logic [10:0] capq[$];

    always #4 clk = ~clk;

    assign rxd_line = loop_mode ? txd : rxd_drv;

    uart_frame_engine #(.DIV_W(16), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst(rst),
        .cfg_enable(g_en), .cfg_tx_en(t_en), .cfg_rx_en(r_en),
        .cfg_width(wsel), .cfg_par_en(pe), .cfg_par_even(ev),
        .cfg_two_stop(ts), .cfg_stop_is_break(sb),
        .cfg_divisor(div), .cfg_sample(smp),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd),
        .rxd(rxd_line), .rx_data(rx_data), .rx_par_err(rx_par_err),
        .rx_stop_err(rx_stop_err), .rx_break(rx_break),
        .rx_valid(rx_valid), .rx_ready(rx_ready)
    );

    // Capture taken characters 1 ns after the falling edge, clear of all stimulus changes.
    always @(negedge clk) begin
        #1;
        if (!rst && rx_valid && rx_ready)
            capq.push_back({rx_break, rx_stop_err, rx_par_err, rx_data});
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic int nbits();
        return 5 + int'(wsel);
    endfunction

    function automatic logic [7:0] dmask();
        return 8'((1 << nbits()) - 1);
    endfunction

    function automatic logic [15:0] bframe(input logic [7:0] d);
        logic [15:0] f;
        logic [7:0]  m;
        int p;
        m = d & dmask();
        f = 16'hFFFF;
        f[0] = 1'b0;
        for (int i = 0; i < nbits(); i++) f[1+i] = m[i];
        p = 1 + nbits();
        if (pe) begin
            f[p] = ev ? ^m : ~^m;
            p++;
        end
        return f;
    endfunction

    function automatic int blen();
        return 2 + nbits() + int'(pe) + int'(ts);
    endfunction

    task automatic tx_send(input logic [7:0] d);
        logic [15:0] f;
        logic [15:0] got;
        int L;
        f = bframe(d);
        L = blen();
        got = 16'hFFFF;
        @(negedge clk);
        tx_data  = d;
        tx_valid = 1'b1;
        while (!tx_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
        for (int k = 0; k < L; k++) begin
            repeat ((k == 0) ? int'(div) / 2 : int'(div)) @(posedge clk);
            @(negedge clk);
            got[k] = txd;
            if (k == 0) chk("R14 ready low in frame", 32'(tx_ready), 32'd0);
        end
        chk("R2 line waveform", 32'(got), 32'(f));
        repeat (int'(div) + 8) @(negedge clk);
    endtask

    task automatic rx_drive(input logic [15:0] f, input int L, input bit inv_half);
        @(negedge clk);
        for (int k = 0; k < L; k++) begin
            if (inv_half && k >= 1 && k <= nbits()) begin
                rxd_drv = f[k];
                repeat (int'(div) / 2) @(negedge clk);
                rxd_drv = ~f[k];
                repeat (int'(div) - int'(div) / 2) @(negedge clk);
            end else begin
                rxd_drv = f[k];
                repeat (int'(div)) @(negedge clk);
            end
        end
        rxd_drv = 1'b1;
        repeat (2 * int'(div) + 8) @(negedge clk);
    endtask

    task automatic expect_rx(input string req, input logic [7:0] d, input logic [2:0] flags);
        logic [10:0] c;
        chk({req, " char count"}, 32'(capq.size()), 32'd1);
        if (capq.size() > 0) begin
            c = capq.pop_front();
            chk({req, " data"}, 32'(c[7:0]), 32'(d));
            chk({req, " flags brk/stop/par"}, 32'(c[10:8]), 32'(flags));
        end
        capq.delete();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [15:0] f;
        logic [7:0]  d;
        int unused_seed;
        unused_seed = $urandom(32'd20240611);

        repeat (5) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 txd idle", 32'(txd), 32'd1);
        chk("R1 rx_valid", 32'(rx_valid), 32'd0);
        chk("R1 tx_ready off", 32'(tx_ready), 32'd0);
        // R6 enables
        t_en = 1'b1;
        @(negedge clk);
        chk("R6 tx_en without global", 32'(tx_ready), 32'd0);
        g_en = 1'b1;
        r_en = 1'b1;
        @(negedge clk);
        chk("R6 ready when enabled", 32'(tx_ready), 32'd1);

        // R2/R3 8N1 loopback
        wsel = 2'd3; pe = 0; ts = 0; div = 16'd8; smp = 16'd4;
        tx_send(8'hA5);
        expect_rx("R3 8-bit", 8'hA5, 3'b000);
        // R3 5-bit, upper bits zero (R13)
        wsel = 2'd0;
        tx_send(8'hFF);
        expect_rx("R13 5-bit upper zero", 8'h1F, 3'b000);
        wsel = 2'd1;
        tx_send(8'hC6);
        expect_rx("R3 6-bit", 8'h06, 3'b000);
        // R4 parity even and odd, R5 two stops
        wsel = 2'd2; pe = 1; ev = 1;
        tx_send(8'h35);
        expect_rx("R4 even parity", 8'h35, 3'b000);
        ev = 0; ts = 1;
        tx_send(8'h35);
        expect_rx("R5 odd parity two stops", 8'h35, 3'b000);

        // Random loopback
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            wsel = 2'($urandom_range(0, 3));
            pe   = 1'($urandom_range(0, 1));
            ev   = 1'($urandom_range(0, 1));
            ts   = 1'($urandom_range(0, 1));
            div  = 16'($urandom_range(4, 20));
            smp  = div / 2;
            d    = 8'($urandom_range(0, 255));
            tx_send(d);
            expect_rx("R2 R4 random loopback", d & dmask(), 3'b000);
        end

        // Directed receive cases driven by the bench
        loop_mode = 1'b0;
        wsel = 2'd3; pe = 1; ev = 1; ts = 0; sb = 0; div = 16'd16; smp = 16'd8;
        f = bframe(8'h3C);
        f[9] = ~f[9];
        rx_drive(f, blen(), 1'b0);
        expect_rx("R9 parity error", 8'h3C, 3'b001);

        pe = 0;
        f = bframe(8'h5A);
        f[9] = 1'b0;
        rx_drive(f, blen(), 1'b0);
        expect_rx("R10 stop error", 8'h5A, 3'b010);
        rx_drive(bframe(8'h81), blen(), 1'b0);
        expect_rx("R10 recovery", 8'h81, 3'b000);

        rx_drive(16'h0000, blen() + 2, 1'b0);
        expect_rx("R11 break", 8'h00, 3'b110);

        sb = 1'b1;
        f = bframe(8'h5A);
        f[9] = 1'b0;
        rx_drive(f, blen(), 1'b0);
        expect_rx("R12 stop as break", 8'h5A, 3'b110);
        sb = 1'b0;

        // R8 false start: 2-cycle low pulse
        @(negedge clk);
        rxd_drv = 1'b0;
        repeat (2) @(negedge clk);
        rxd_drv = 1'b1;
        repeat (3 * int'(div)) @(negedge clk);
        chk("R8 false start dropped", 32'(capq.size()), 32'd0);
        capq.delete();

        // R8 sample offset: each data bit inverted in its second half
        smp = 16'd2;
        rx_drive(bframe(8'h96), blen(), 1'b1);
        expect_rx("R8 early sample", 8'h96, 3'b000);
        smp = 16'd12;
        rx_drive(bframe(8'h96), blen(), 1'b1);
        expect_rx("R8 late sample", 8'h69, 3'b000);
        smp = 16'd8;

        // R13 hold until taken
        @(negedge clk);
        rx_ready = 1'b0;
        rx_drive(bframe(8'h77), blen(), 1'b0);
        repeat (50) @(negedge clk);
        chk("R13 valid held", 32'(rx_valid), 32'd1);
        chk("R13 data held", 32'(rx_data), 32'h77);
        chk("R13 nothing taken", 32'(capq.size()), 32'd0);
        rx_ready = 1'b1;
        repeat (2) @(negedge clk);
        expect_rx("R13 taken", 8'h77, 3'b000);

        // R7 receiver disabled
        r_en = 1'b0;
        rx_drive(bframe(8'h42), blen(), 1'b0);
        chk("R7 rx disabled", 32'(capq.size()), 32'd0);
        chk("R7 rx_valid low", 32'(rx_valid), 32'd0);
        r_en = 1'b1;
        capq.delete();

        // R6 transmitter disabled via global enable
        g_en = 1'b0;
        tx_valid = 1'b1;
        repeat (20) @(negedge clk);
        chk("R6 ready off", 32'(tx_ready), 32'd0);
        chk("R6 line high", 32'(txd), 32'd1);
        tx_valid = 1'b0;
        g_en = 1'b1;

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule